// File: doc/BRIEF.md
# Pixel Point ALU with Output Shifter

This block applies a point operation to every pixel of an 8-bit raster stream, ahead of the line storage of a two-dimensional filter. Each incoming pixel first passes through a short register delay whose depth is set by a select input. The delayed pixel becomes operand A. Operand B is a byte held in a local register. That register is written from the configuration data bus by its own strobe, and this strobe has no connection to any register-write decoding.

A 10-bit microcode word arrives on an input. Its low seven bits choose a logical function (a four-bit truth table) or one of three modular arithmetic operations. Its top three bits choose a logical right shift or a zero-filling left shift of one to three places. The shift acts on the result of whichever operation is chosen. Microcode values that are not defined make the block pass A through unchanged. The processed pixel is registered, and a valid flag goes with it.

Top module: `pixel_point_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `pix_out` and `out_vld` are zero after that edge and the B register is cleared to zero. A B-select operation on the first pixel after reset therefore yields 0.
- R2: A pixel presented with `pix_vld` high at edge k appears on `pix_out` with `out_vld` high right after edge k+D, where D is the value of `dly_sel` (0 to 3 extra register stages). Pixels leave in the order they entered.
- R3: When `ucode[2:0]` is 000, `ucode[6:3]` is a truth table. Output bit i equals the table bit at index {~A[i],~B[i]}. The accepted tables are 0000 (zero), 1111 (ones), 0011 (A), 0101 (B), 1100 (not A), 1010 (not B), 0001 (and), 0111 (or), 0110 (xor), 1001 (xnor), 1110 (nand) and 1000 (nor).
- R4: `ucode[6:0]` = 0110001 gives A+B, 1001010 gives A-B and 1001100 gives B-A, all modulo 256.
- R5: `ucode[9:7]` sets the shift applied to the operation result. 000 means no shift. 001, 010 and 011 are logical right shifts by 1, 2 and 3. 100, 101 and 110 are left shifts by 1, 2 and 3 that fill with zeros and drop the bits shifted out.
- R6: Shift code 111, and any `ucode[6:0]` value not listed in R3 or R4, output A unshifted.
- R7: The B register takes `cfg_data` at a rising edge where `b_load` is high. At every other edge it keeps its value, whatever `cfg_data` does.
- R8: A cycle with `pix_vld` low produces no output. `out_vld` stays low for it and `pix_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 8 | Incoming pixel |
| pix_vld | input | 1 | Marks `pix_in` as a pixel |
| dly_sel | input | 2 | Number of delay stages ahead of the ALU (0 to 3) |
| ucode | input | 10 | Operation in bits 6:0, shift in bits 9:7 |
| cfg_data | input | 8 | Configuration data, source for the B register |
| b_load | input | 1 | Writes `cfg_data` into the B register |
| pix_out | output | 8 | Processed pixel |
| out_vld | output | 1 | Marks `pix_out` as a new result |

## Verification
A corrupted B register shows up on the first pixel that is processed with a B-dependent function after the corruption. Every such result is wrong until `b_load` writes the register again. A delay stage that is dropped or doubled, or a valid bit that gets out of step with its pixel, appears on the very next output as an early or late `out_vld` pulse. It also appears as pixels that reach `pix_out` in the wrong order. A fault in the decode of a single truth-table position or shift code affects only the pixels processed under that microcode. For that reason each code is run against operand pairs chosen so that every bit position takes part.

// File: rtl/pixel_alu_pkg.sv
package pixel_alu_pkg;

    localparam int PIX_W = 8;
    localparam int UC_W  = 10;
    localparam int FN_W  = 4;
    localparam int AMT_W = 2;

    typedef enum logic [2:0] {
        K_LOGIC,
        K_ADD,
        K_SUB_AB,
        K_SUB_BA,
        K_PASS
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e        kind;
        logic [FN_W-1:0]  fn;
        logic             left;
        logic [AMT_W-1:0] amt;
    } alu_cmd_t;

    // Truth tables that the logic field accepts.
    function automatic logic fn_known(input logic [FN_W-1:0] f);
        case (f)
            4'b0000, 4'b1111, 4'b0011, 4'b0101,
            4'b1100, 4'b1010, 4'b0001, 4'b0111,
            4'b0110, 4'b1001, 4'b1110, 4'b1000: return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

    function automatic alu_cmd_t decode_cmd(input logic [UC_W-1:0] uc);
        alu_cmd_t c;
        c.fn   = uc[6:3];
        c.kind = K_PASS;
        c.left = 1'b0;
        c.amt  = '0;
        if (uc[2:0] == 3'b000 && fn_known(uc[6:3]))
            c.kind = K_LOGIC;
        else if (uc[6:0] == 7'b0110001)
            c.kind = K_ADD;
        else if (uc[6:0] == 7'b1001010)
            c.kind = K_SUB_AB;
        else if (uc[6:0] == 7'b1001100)
            c.kind = K_SUB_BA;
        case (uc[9:7])
            3'b000: c.amt = '0;
            3'b001, 3'b010, 3'b011: c.amt = uc[8:7];
            3'b100, 3'b101, 3'b110: begin
                c.left = 1'b1;
                c.amt  = uc[8:7] + 2'd1;
            end
            default: c.kind = K_PASS;
        endcase
        if (c.kind == K_PASS) begin
            c.left = 1'b0;
            c.amt  = '0;
        end
        return c;
    endfunction

endpackage

// File: rtl/ppa_delay_line.sv
module ppa_delay_line #(
    parameter int W      = 8,
    parameter int STAGES = 3,
    parameter int SEL_W  = $clog2(STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     in_data,
    input  logic             in_vld,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     out_data,
    output logic             out_vld
);

    logic [W-1:0] st_d [STAGES];
    logic         st_v [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_d[g] <= '0;
                    st_v[g] <= 1'b0;
                end else begin
                    st_d[g] <= in_data;
                    st_v[g] <= in_vld;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_d[g] <= '0;
                    st_v[g] <= 1'b0;
                end else begin
                    st_d[g] <= st_d[g-1];
                    st_v[g] <= st_v[g-1];
                end
            end
        end
    end

    always_comb begin
        out_data = in_data;
        out_vld  = in_vld;
        for (int i = 0; i < STAGES; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                out_data = st_d[i];
                out_vld  = st_v[i];
            end
        end
    end

endmodule

// File: rtl/ppa_logic_unit.sv
module ppa_logic_unit
    import pixel_alu_pkg::*;
#(
    parameter int W = PIX_W
) (
    input  alu_cmd_t     cmd,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic [W-1:0] tt_y;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign tt_y[g] = cmd.fn[{~a[g], ~b[g]}];
    end

    always_comb begin
        case (cmd.kind)
            K_LOGIC:  y = tt_y;
            K_ADD:    y = a + b;
            K_SUB_AB: y = a - b;
            K_SUB_BA: y = b - a;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/ppa_shifter.sv
module ppa_shifter #(
    parameter int W     = 8,
    parameter int AMT_W = 2
) (
    input  logic [W-1:0]     in_v,
    input  logic             left,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     out_v
);

    always_comb begin
        if (left)
            out_v = in_v << amt;
        else
            out_v = in_v >> amt;
    end

endmodule

// File: rtl/pixel_point_alu.sv
module pixel_point_alu
    import pixel_alu_pkg::*;
#(
    parameter  int PIX_W  = pixel_alu_pkg::PIX_W,
    parameter  int STAGES = 3,
    localparam int SEL_W  = $clog2(STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             pix_vld,
    input  logic [SEL_W-1:0] dly_sel,
    input  logic [UC_W-1:0]  ucode,
    input  logic [PIX_W-1:0] cfg_data,
    input  logic             b_load,
    output logic [PIX_W-1:0] pix_out,
    output logic             out_vld
);

    alu_cmd_t         cmd;
    logic [PIX_W-1:0] b_q;
    logic [PIX_W-1:0] tap_pix;
    logic             tap_vld;
    logic [PIX_W-1:0] alu_y;
    logic [PIX_W-1:0] shf_y;

    assign cmd = decode_cmd(ucode);

    // Operand B register, written only by its own strobe
    always_ff @(posedge clk) begin
        if (rst)
            b_q <= '0;
        else if (b_load)
            b_q <= cfg_data;
    end

    ppa_delay_line #(
        .W      (PIX_W),
        .STAGES (STAGES),
        .SEL_W  (SEL_W)
    ) u_dly (
        .clk      (clk),
        .rst      (rst),
        .in_data  (pix_in),
        .in_vld   (pix_vld),
        .sel      (dly_sel),
        .out_data (tap_pix),
        .out_vld  (tap_vld)
    );

    ppa_logic_unit #(
        .W (PIX_W)
    ) u_alu (
        .cmd (cmd),
        .a   (tap_pix),
        .b   (b_q),
        .y   (alu_y)
    );

    ppa_shifter #(
        .W     (PIX_W),
        .AMT_W (AMT_W)
    ) u_shf (
        .in_v  (alu_y),
        .left  (cmd.left),
        .amt   (cmd.amt),
        .out_v (shf_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= tap_vld;
            if (tap_vld)
                pix_out <= shf_y;
        end
    end

endmodule

// File: rtl/pixel_point_alu_chk.sv
module pixel_point_alu_chk #(
    parameter int PIX_W = 8,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_vld,
    input logic [SEL_W-1:0] dly_sel,
    input logic             b_load,
    input logic [PIX_W-1:0] cfg_data,
    input logic [PIX_W-1:0] b_q,
    input logic [PIX_W-1:0] pix_out,
    input logic             out_vld
);

    localparam int HIST = 1 << SEL_W;

    logic [HIST-1:0]  vh;
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        sel_q <= dly_sel;
        if (rst)
            vh <= '0;
        else
            vh <= {vh[HIST-2:0], pix_vld};
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_vld && pix_out == '0 && b_q == '0));

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_vld == vh[sel_q]);

    a_r7_b_loads: assert property (@(posedge clk) disable iff (rst)
        b_load |=> (b_q == $past(cfg_data)));

    a_r7_b_holds: assert property (@(posedge clk) disable iff (rst)
        !b_load |=> $stable(b_q));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!out_vld && !$past(rst)) |-> $stable(pix_out));

endmodule

bind pixel_point_alu pixel_point_alu_chk #(
    .PIX_W (PIX_W),
    .SEL_W (SEL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pix_vld  (pix_vld),
    .dly_sel  (dly_sel),
    .b_load   (b_load),
    .cfg_data (cfg_data),
    .b_q      (b_q),
    .pix_out  (pix_out),
    .out_vld  (out_vld)
);

// File: tb/pixel_point_alu_bench.sv
`timescale 1ns/1ps
module pixel_point_alu_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_in = '0;
    logic       pix_vld = 1'b0;
    logic [1:0] dly_sel = '0;
    logic [9:0] ucode = 10'b000_0011000;
    logic [7:0] cfg_data = '0;
    logic       b_load = 1'b0;
    logic [7:0] pix_out;
    logic       out_vld;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0] cur_b = '0;
    logic [7:0] last_out = '0;

    logic [7:0] exp_q[$];
    int         due_q[$];
    string      tag_q[$];

    pixel_point_alu u_pixel_point_alu (
        .clk      (clk),
        .rst      (rst),
        .pix_in   (pix_in),
        .pix_vld  (pix_vld),
        .dly_sel  (dly_sel),
        .ucode    (ucode),
        .cfg_data (cfg_data),
        .b_load   (b_load),
        .pix_out  (pix_out),
        .out_vld  (out_vld)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b, input logic [9:0] uc);
        logic [7:0] r;
        logic ok;
        ok = 1'b1;
        r = a;
        case (uc[6:0])
            7'b0000000: r = 8'h00;
            7'b1111000: r = 8'hFF;
            7'b0011000: r = a;
            7'b0101000: r = b;
            7'b1100000: r = ~a;
            7'b1010000: r = ~b;
            7'b0001000: r = a & b;
            7'b0111000: r = a | b;
            7'b0110000: r = a ^ b;
            7'b1001000: r = ~(a ^ b);
            7'b1110000: r = ~(a & b);
            7'b1000000: r = ~(a | b);
            7'b0110001: r = a + b;
            7'b1001010: r = a - b;
            7'b1001100: r = b - a;
            default:    ok = 1'b0;
        endcase
        if (uc[9:7] == 3'b111) ok = 1'b0;
        if (!ok) return a;
        case (uc[9:7])
            3'd1: r = r >> 1;
            3'd2: r = r >> 2;
            3'd3: r = r >> 3;
            3'd4: r = r << 1;
            3'd5: r = r << 2;
            3'd6: r = r << 3;
            default: ;
        endcase
        return r;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] p, input string tag);
        pix_in  = p;
        pix_vld = 1'b1;
        exp_q.push_back(model(p, cur_b, ucode));
        due_q.push_back(cyc + 1 + int'(dly_sel));
        tag_q.push_back(tag);
        @(negedge clk);
        pix_vld = 1'b0;
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
    endtask

    task automatic load_b(input logic [7:0] v);
        cfg_data = v;
        b_load   = 1'b1;
        @(negedge clk);
        b_load   = 1'b0;
        cur_b    = v;
    endtask

    // Monitor: pops expected results and checks value, order and timing
    always @(negedge clk) begin
        if (rst) begin
            last_out <= '0;
        end else if (out_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected output", int'(pix_out), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic int d = due_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(pix_out == e, t, int'(pix_out), int'(e));
                check(cyc == d, "R2 latency", cyc, d);
            end
            last_out <= pix_out;
        end else begin
            check(pix_out == last_out, "R8 idle hold", int'(pix_out), int'(last_out));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [9:0] logic_ops [12] = '{10'b000_0000000, 10'b000_1111000, 10'b000_0011000,
                                  10'b000_0101000, 10'b000_1100000, 10'b000_1010000,
                                  10'b000_0001000, 10'b000_0111000, 10'b000_0110000,
                                  10'b000_1001000, 10'b000_1110000, 10'b000_1000000};

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset
        check(out_vld == 1'b0, "R1 reset out_vld", int'(out_vld), 0);
        check(pix_out == 8'h00, "R1 reset pix_out", int'(pix_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0, "R1 after reset out_vld", int'(out_vld), 0);
        // R1: B register starts at zero
        ucode = 10'b000_0101000;
        send(8'h77, "R1 B cleared");
        drain();

        // R2: each delay setting, pass-through of A
        ucode = 10'b000_0011000;
        for (int d = 0; d < 4; d++) begin
            dly_sel = 2'(d);
            @(negedge clk);
            for (int i = 0; i < 5; i++) send(8'(8'h11 * i + d), "R2 delay");
            drain();
        end

        // R3: every truth table, operand pairs covering each bit combination
        dly_sel = 2'd1;
        load_b(8'h5A);
        for (int k = 0; k < 12; k++) begin
            ucode = logic_ops[k];
            send(8'h3C, "R3 logic");
            send(8'hF0, "R3 logic");
            send(8'h00, "R3 logic");
            drain();
        end

        // R4: arithmetic with wrap
        dly_sel = 2'd2;
        load_b(8'hC3);
        ucode = 10'b000_0110001;
        send(8'hF0, "R4 add wrap"); send(8'h01, "R4 add");
        drain();
        ucode = 10'b000_1001010;
        send(8'h10, "R4 A-B wrap"); send(8'hFF, "R4 A-B");
        drain();
        ucode = 10'b000_1001100;
        send(8'h10, "R4 B-A"); send(8'hFF, "R4 B-A wrap");
        drain();

        // R5: every valid shift on an arithmetic and a logic result
        dly_sel = 2'd0;
        for (int s = 1; s < 7; s++) begin
            ucode = {3'(s), 7'b0110001};
            send(8'h2D, "R5 shift add");
            ucode = {3'(s), 7'b0110000};
            send(8'hB4, "R5 shift xor");
            drain();
        end

        // R6: invalid shift and unlisted operation codes pass A
        ucode = {3'b111, 7'b0110001};
        send(8'h9E, "R6 shift 111");
        ucode = 10'b000_0010000;
        send(8'h9E, "R6 unlisted logic");
        ucode = 10'b010_1111111;
        send(8'h4B, "R6 unlisted op");
        ucode = 10'b000_0110011;
        send(8'h4B, "R6 unlisted arith");
        drain();

        // R7: B ignores cfg_data while b_load is low
        ucode = 10'b000_0101000;
        cfg_data = 8'h33;
        repeat (3) @(negedge clk);
        send(8'h00, "R7 B held");
        cfg_data = 8'hEE;
        send(8'h01, "R7 B held");
        drain();
        load_b(8'h81);
        send(8'h02, "R7 B loaded");
        drain();

        // R8: gaps between pixels produce nothing, output holds
        dly_sel = 2'd3;
        ucode = 10'b000_0011000;
        send(8'hA1, "R8 gap");
        repeat (2) @(negedge clk);
        send(8'hA2, "R8 gap");
        send(8'hA3, "R8 gap");
        repeat (3) @(negedge clk);
        send(8'hA4, "R8 gap");
        drain();
        drain();

        check(exp_q.size() == 0, "R2 all outputs seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule